// File: doc/BRIEF.md
# Instruction Ring Distribution Network

The block carries configuration words for a set of processing kernels from a single word source to those kernels over a 32-bit ring. The ring runs in one direction and passes through one transport node per kernel. The source pushes a stream of segments into the ring. Each segment is a header word followed by a run of payload words. A node that recognises its own kernel number in a header removes that header and the payload words behind it from the ring. It writes each of those payload words straight into its kernel's register file as a raw value, with no decoding step. Every other word moves on to the next node unchanged.

A word stream for the next task can be pushed while the kernels finish the current one. Reprogramming a kernel therefore costs roughly its payload length plus the ring depth in cycles. Adding a kernel means adding one more node to the chain, and the existing nodes do not change. Words that no node claims leave through the ring's exit port. The exit port either feeds a further ring section or serves as an observation point.

Top module: `instr_ring`

## Requirements
- R1: Words that no node claims leave the exit port with their 32-bit contents unchanged and in the order the source gave them.
- R2: A header word carries the target kernel number in bits [31:24] and the payload length in bits [15:0]. Bits [23:16] have no effect on routing. Node k answers to kernel number BASE_ID + k.
- R3: A node that matches a header keeps that header and exactly the stated number of following words off the ring. The next word after that is treated as a new header.
- R4: Each claimed payload word produces one write pulse on that node's kernel port. The pulse carries the word as data and an index that starts at 0 for each segment and rises by one per word. For node k, the pulse appears k+1 cycles after the source handshake of that word.
- R5: A node's done pulse comes in the same cycle as the write of the last payload word of its segment. A matched header of length 0 gives a done pulse with no write, k+1 cycles after its source handshake.
- R6: A segment for another kernel passes through a node with its header, and leaves that node's length tracking in step. A later node on the ring still receives and claims its own segment correctly.
- R7: Each node adds exactly one register stage. With the exit port ready, an unclaimed word leaves NUM_KERNELS cycles after its source handshake, and back-to-back words move one per cycle.
- R8: When the exit port stalls, the exit word holds steady and the ring fills one word per node. The source is then refused. Once the stall ends, every word leaves exactly once and in order.
- R9: After reset, no exit word is valid, no write or done pulse is active, and the source is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcValid | input | 1 | Source word available |
| srcData | input | 32 | Source word |
| srcReady | output | 1 | Ring accepts the source word |
| ringOutValid | output | 1 | Unclaimed word at the ring exit |
| ringOutData | output | 32 | Unclaimed word |
| ringOutReady | input | 1 | Exit consumer takes the word |
| cfgWrEn | output | NUM_KERNELS | Per-kernel register write pulse |
| cfgWrIdx | output | NUM_KERNELS*8 | Per-kernel register index, kernel k at bits [8k+7:8k] |
| cfgWrData | output | NUM_KERNELS*32 | Per-kernel write data, kernel k at bits [32k+31:32k] |
| cfgDone | output | NUM_KERNELS | Per-kernel segment-complete pulse |

## Verification
Each source handshake is stamped with a cycle number. A monitor logs exit words, writes and done pulses at the falling edge, each with the cycle in which it appears. The checks use fixed offsets from the source stamp. An unclaimed word is due NUM_KERNELS cycles after its handshake. A write or a zero-length done at node k is due k+1 cycles after its handshake. A done pulse for a segment with payload must share the cycle of the last write. In the stall scenario the ring is checked while it is stalled and full: three words accepted and the source refused. It is checked again after release, when all five words must have left once each and in order.

// File: rtl/instr_ring_pkg.sv
package instr_ring_pkg;
  // Control-to-datapath strobes of one transport node, valid in the accept cycle.
  typedef struct packed {
    logic fwd;   // pass the input word on to the next node
    logic wr;    // write the input word to the kernel register file
    logic done;  // this accept completes the node's own segment
  } nodeStrobe_t;
endpackage

// File: rtl/ring_node_ctrl.sv
module ring_node_ctrl
  import instr_ring_pkg::*;
#(
  parameter int MY_ID = 0,
  parameter int ID_W  = 8,
  parameter int CNT_W = 16,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [ID_W-1:0]  hdrId,
  input  logic [CNT_W-1:0] hdrCount,
  input  logic             outValid,
  input  logic             outReady,
  output logic             inReady,
  output nodeStrobe_t      strobe,
  output logic [IDX_W-1:0] wrIdx
);
  logic [CNT_W-1:0] remaining;
  logic             mine;
  logic [IDX_W-1:0] idxQ;
  logic             accept, isHdr, hdrMine;

  assign inReady = !outValid || outReady;
  assign accept  = inValid && inReady;
  assign isHdr   = (remaining == '0);
  assign hdrMine = (hdrId == ID_W'(MY_ID));
  assign wrIdx   = idxQ;

  always_comb begin
    strobe.fwd  = accept && (isHdr ? !hdrMine : !mine);
    strobe.wr   = accept && !isHdr && mine;
    strobe.done = accept && ((isHdr && hdrMine && hdrCount == '0) ||
                             (!isHdr && mine && remaining == CNT_W'(1)));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remaining <= '0;
      mine      <= 1'b0;
      idxQ      <= '0;
    end else if (accept) begin
      if (isHdr) begin
        remaining <= hdrCount;
        mine      <= hdrMine;
        idxQ      <= '0;
      end else begin
        remaining <= remaining - 1'b1;
        if (mine) idxQ <= idxQ + 1'b1;
      end
    end
  end

  // R2
  hdr_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    accept && isHdr |=> remaining == $past(hdrCount));

  // R5
  done_ends_seg_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.done |=> remaining == '0);

  // R3
  claim_no_fwd_chk: assert property (@(posedge clk) disable iff (!rstN)
    mine && !isHdr && accept |-> !strobe.fwd);
endmodule

// File: rtl/ring_node_dp.sv
module ring_node_dp
  import instr_ring_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] inData,
  input  nodeStrobe_t       strobe,
  input  logic [IDX_W-1:0]  wrIdxIn,
  input  logic              outReady,
  output logic              outValid,
  output logic [WORD_W-1:0] outData,
  output logic              cfgWrEn,
  output logic [IDX_W-1:0]  cfgWrIdx,
  output logic [WORD_W-1:0] cfgWrData,
  output logic              cfgDone
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      outData   <= '0;
      cfgWrEn   <= 1'b0;
      cfgWrIdx  <= '0;
      cfgWrData <= '0;
      cfgDone   <= 1'b0;
    end else begin
      if (strobe.fwd) begin
        outValid <= 1'b1;
        outData  <= inData;
      end else if (outReady) begin
        outValid <= 1'b0;
      end
      cfgWrEn <= strobe.wr;
      cfgDone <= strobe.done;
      if (strobe.wr) begin
        cfgWrIdx  <= wrIdxIn;
        cfgWrData <= inData;
      end
    end
  end

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outData));

  // R4
  idx_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrEn |=> !cfgWrEn || cfgWrIdx == '0 || cfgWrIdx == $past(cfgWrIdx) + 1'b1);

  // R7
  one_stage_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> $past(strobe.fwd));
endmodule

// File: rtl/instr_ring.sv
module instr_ring
  import instr_ring_pkg::*;
#(
  parameter int NUM_KERNELS = 3,
  parameter int BASE_ID     = 16,
  parameter int WORD_W      = 32,
  parameter int ID_W        = 8,
  parameter int CNT_W       = 16,
  parameter int IDX_W       = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          srcValid,
  input  logic [WORD_W-1:0]             srcData,
  output logic                          srcReady,
  output logic                          ringOutValid,
  output logic [WORD_W-1:0]             ringOutData,
  input  logic                          ringOutReady,
  output logic [NUM_KERNELS-1:0]        cfgWrEn,
  output logic [NUM_KERNELS*IDX_W-1:0]  cfgWrIdx,
  output logic [NUM_KERNELS*WORD_W-1:0] cfgWrData,
  output logic [NUM_KERNELS-1:0]        cfgDone
);
  localparam int ID_LSB = WORD_W - ID_W;

  logic              linkValid [NUM_KERNELS+1];
  logic              linkReady [NUM_KERNELS+1];
  logic [WORD_W-1:0] linkData  [NUM_KERNELS+1];

  assign linkValid[0] = srcValid;
  assign linkData[0]  = srcData;
  assign srcReady     = linkReady[0];

  assign ringOutValid           = linkValid[NUM_KERNELS];
  assign ringOutData            = linkData[NUM_KERNELS];
  assign linkReady[NUM_KERNELS] = ringOutReady;

  for (genvar k = 0; k < NUM_KERNELS; k++) begin : g_node
    nodeStrobe_t      strobe;
    logic [IDX_W-1:0] wrIdx;

    ring_node_ctrl #(
      .MY_ID(BASE_ID + k), .ID_W(ID_W), .CNT_W(CNT_W), .IDX_W(IDX_W)
    ) u_ctrl (
      .clk      (clk),
      .rstN     (rstN),
      .inValid  (linkValid[k]),
      .hdrId    (linkData[k][WORD_W-1:ID_LSB]),
      .hdrCount (linkData[k][CNT_W-1:0]),
      .outValid (linkValid[k+1]),
      .outReady (linkReady[k+1]),
      .inReady  (linkReady[k]),
      .strobe   (strobe),
      .wrIdx    (wrIdx)
    );

    ring_node_dp #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_dp (
      .clk       (clk),
      .rstN      (rstN),
      .inData    (linkData[k]),
      .strobe    (strobe),
      .wrIdxIn   (wrIdx),
      .outReady  (linkReady[k+1]),
      .outValid  (linkValid[k+1]),
      .outData   (linkData[k+1]),
      .cfgWrEn   (cfgWrEn[k]),
      .cfgWrIdx  (cfgWrIdx[k*IDX_W +: IDX_W]),
      .cfgWrData (cfgWrData[k*WORD_W +: WORD_W]),
      .cfgDone   (cfgDone[k])
    );
  end

  // R9
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |=> !ringOutValid && cfgWrEn == '0 && cfgDone == '0);
endmodule

// File: tb/instr_ring_tb.sv
module instr_ring_tb;
  localparam int NK = 3;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              srcValid = 1'b0;
  logic [31:0]       srcData = '0;
  logic              srcReady;
  logic              ringOutValid;
  logic [31:0]       ringOutData;
  logic              ringOutReady = 1'b1;
  logic [NK-1:0]     cfgWrEn;
  logic [NK*8-1:0]   cfgWrIdx;
  logic [NK*32-1:0]  cfgWrData;
  logic [NK-1:0]     cfgDone;

  instr_ring #(.NUM_KERNELS(NK), .BASE_ID(16)) u_dut (
    .clk(clk), .rstN(rstN), .srcValid(srcValid), .srcData(srcData),
    .srcReady(srcReady), .ringOutValid(ringOutValid), .ringOutData(ringOutData),
    .ringOutReady(ringOutReady), .cfgWrEn(cfgWrEn), .cfgWrIdx(cfgWrIdx),
    .cfgWrData(cfgWrData), .cfgDone(cfgDone)
  );

  always #10 clk = ~clk;  // 50 MHz

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int errors = 0, checks = 0;
  int srcCnt, outCnt, wrCnt, doneCnt;
  int srcCyc [64];
  int outCyc [64];
  logic [31:0] outLog [64];
  int wrNode [64];
  int wrIdxL [64];
  int wrCycL [64];
  logic [31:0] wrDataL [64];
  int doneNode [64];
  int doneCyc [64];

  always @(negedge clk) begin
    if (rstN) begin
      if (srcValid && srcReady && srcCnt < 64) begin
        srcCyc[srcCnt] = cyc; srcCnt++;
      end
      if (ringOutValid && ringOutReady && outCnt < 64) begin
        outLog[outCnt] = ringOutData; outCyc[outCnt] = cyc; outCnt++;
      end
      for (int k = 0; k < NK; k++) begin
        if (cfgWrEn[k] && wrCnt < 64) begin
          wrNode[wrCnt] = k; wrIdxL[wrCnt] = int'(cfgWrIdx[k*8 +: 8]);
          wrDataL[wrCnt] = cfgWrData[k*32 +: 32]; wrCycL[wrCnt] = cyc; wrCnt++;
        end
        if (cfgDone[k] && doneCnt < 64) begin
          doneNode[doneCnt] = k; doneCyc[doneCnt] = cyc; doneCnt++;
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic clearLogs();
    srcCnt = 0; outCnt = 0; wrCnt = 0; doneCnt = 0;
  endtask

  task automatic sendWord(input logic [31:0] w);
    srcValid = 1'b1; srcData = w;
    do @(negedge clk); while (!srcReady);
    @(posedge clk); #1;
    srcValid = 1'b0;
  endtask

  task automatic drain();
    repeat (12) @(posedge clk);
    #1;
  endtask

  function automatic int findWrite(input int node, input int idx);
    for (int i = 0; i < wrCnt; i++)
      if (wrNode[i] == node && wrIdxL[i] == idx) return i;
    return -1;
  endfunction

  function automatic int countDone(input int node);
    int n = 0;
    for (int i = 0; i < doneCnt; i++) if (doneNode[i] == node) n++;
    return n;
  endfunction

  task automatic testReset();
    @(negedge clk);
    check(srcReady == 1'b1, "R9", "srcReady after reset", 32'(srcReady), 1);
    check(ringOutValid == 1'b0, "R9", "ringOutValid after reset", 32'(ringOutValid), 0);
    check(cfgWrEn == '0 && cfgDone == '0, "R9", "pulses after reset",
          32'({cfgWrEn, cfgDone}), 0);
    @(posedge clk); #1;
  endtask

  task automatic testPassthrough();
    logic [31:0] w [3];
    w[0] = 32'h4000_0002; w[1] = 32'hDEAD_0001; w[2] = 32'h0000_0000;
    clearLogs();
    for (int i = 0; i < 3; i++) sendWord(w[i]);
    drain();
    check(outCnt == 3, "R1", "passthrough word count", 32'(outCnt), 3);
    for (int i = 0; i < 3; i++)
      check(outLog[i] == w[i], "R6", "foreign segment word", outLog[i], w[i]);
    check(wrCnt == 0, "R6", "no writes for foreign segment", 32'(wrCnt), 0);
    check(outCyc[0] - srcCyc[0] == NK, "R7", "exit latency",
          32'(outCyc[0] - srcCyc[0]), NK);
    check(outCyc[2] - outCyc[0] == 2, "R7", "back-to-back spacing",
          32'(outCyc[2] - outCyc[0]), 2);
  endtask

  task automatic testProgramOne();
    logic [31:0] p [3];
    int j;
    p[0] = 32'h0000_0040; p[1] = 32'h0000_0007; p[2] = 32'h8000_0001;
    clearLogs();
    sendWord(32'h11AB_0003);  // kernel 0x11, junk in bits 23:16
    for (int i = 0; i < 3; i++) sendWord(p[i]);
    drain();
    check(outCnt == 0, "R3", "claimed words kept off ring", 32'(outCnt), 0);
    check(wrCnt == 3, "R2", "write count for matched header", 32'(wrCnt), 3);
    for (int i = 0; i < 3; i++) begin
      j = findWrite(1, i);
      check(j >= 0 && wrDataL[j] == p[i], "R4", "node1 write data",
            j >= 0 ? wrDataL[j] : 32'hFFFF_FFFF, p[i]);
    end
    j = findWrite(1, 0);
    check(j >= 0 && wrCycL[j] - srcCyc[1] == 2, "R4", "node1 write latency",
          j >= 0 ? 32'(wrCycL[j] - srcCyc[1]) : 0, 2);
    j = findWrite(1, 2);
    check(doneCnt == 1 && doneNode[0] == 1 && j >= 0 && doneCyc[0] == wrCycL[j],
          "R5", "done with last write", 32'(doneCnt), 1);
  endtask

  task automatic testSubgraph();
    int j;
    clearLogs();
    sendWord(32'h1200_0002); sendWord(32'hA0A0_0001); sendWord(32'hB0B0_0002);
    sendWord(32'h1000_0001); sendWord(32'hC0C0_0003);
    sendWord(32'h5500_0001); sendWord(32'h1100_0000);  // foreign payload looks like a header
    sendWord(32'h1100_0000);                            // zero-length segment for node1
    drain();
    j = findWrite(2, 0);
    check(j >= 0 && wrDataL[j] == 32'hA0A0_0001, "R6", "node2 idx0 through ring",
          j >= 0 ? wrDataL[j] : 0, 32'hA0A0_0001);
    j = findWrite(2, 1);
    check(j >= 0 && wrDataL[j] == 32'hB0B0_0002, "R4", "node2 idx1",
          j >= 0 ? wrDataL[j] : 0, 32'hB0B0_0002);
    j = findWrite(0, 0);
    check(j >= 0 && wrDataL[j] == 32'hC0C0_0003, "R4", "node0 idx0",
          j >= 0 ? wrDataL[j] : 0, 32'hC0C0_0003);
    check(wrCnt == 3, "R3", "total writes in subgraph", 32'(wrCnt), 3);
    check(outCnt == 2 && outLog[0] == 32'h5500_0001 && outLog[1] == 32'h1100_0000,
          "R6", "foreign segment with header-like payload exits", outLog[1], 32'h1100_0000);
    check(countDone(0) == 1 && countDone(1) == 1 && countDone(2) == 1, "R5",
          "one done per node", 32'(doneCnt), 3);
    j = -1;
    for (int i = 0; i < doneCnt; i++) if (doneNode[i] == 1) j = i;
    check(j >= 0 && doneCyc[j] - srcCyc[7] == 2, "R5", "zero-length done latency",
          j >= 0 ? 32'(doneCyc[j] - srcCyc[7]) : 0, 2);
  endtask

  task automatic testBackpressure();
    logic [31:0] w [5];
    w[0] = 32'h7700_0004;
    for (int i = 1; i < 5; i++) w[i] = 32'h0BAD_0000 + 32'(i);
    clearLogs();
    ringOutReady = 1'b0;
    fork
      for (int i = 0; i < 5; i++) sendWord(w[i]);
      begin
        repeat (10) @(posedge clk);
        @(negedge clk);
        check(srcReady == 1'b0, "R8", "source refused when full", 32'(srcReady), 0);
        check(srcCnt == NK, "R8", "words held by ring", 32'(srcCnt), NK);
        check(ringOutValid && ringOutData == w[0], "R8", "exit word held",
              ringOutData, w[0]);
        @(posedge clk); #1;
        ringOutReady = 1'b1;
      end
    join
    drain();
    check(outCnt == 5, "R8", "no loss or duplicate", 32'(outCnt), 5);
    for (int i = 0; i < 5; i++)
      check(outLog[i] == w[i], "R8", "order after stall", outLog[i], w[i]);
  endtask

  initial begin
    bit timedOut = 0;
    clearLogs();
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    fork
      begin
        testReset();
        testPassthrough();
        testProgramOne();
        testSubgraph();
        testBackpressure();
      end
      begin
        repeat (100000) @(posedge clk);
        timedOut = 1;
      end
    join_any
    disable fork;
    if (timedOut) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule